// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Front End

This block models the command and data path of a synchronous SRAM that moves data on both edges of its clock, with a fixed burst of two words and a data bus shared by reads and writes. Commands and addresses are taken only on the K rising edge. A write accepts its two data beats on the next K cycle, on the K edge and then the K# edge. A read returns its two beats after a fixed latency, and the output enable is high only while those beats are on the bus.

The K and K# rising edges are modelled as alternating active edges of one clock `clk` that runs at twice the K rate. The output `k_slot` is high when the next enabled edge is a K edge. Deasserting `ck_en` stands for a stopped clock, and the whole block then holds its state. The `LAT25` parameter selects a read latency of 2.0 or 2.5 K cycles.

Top module: `burst2_ddr_sram`

## Requirements
- R1: After reset, `dq_oe` is 0, `dq_out` is 0 and `k_slot` is 1, so the first enabled edge is a K edge.
- R2: `k_slot` toggles on every enabled edge. `ld_n`, `rw_rd` and `addr` are sampled only on edges where `k_slot` was 1. Values applied on K# edges have no effect on storage or on the bus.
- R3: On a K edge, `ld_n`=0 with `rw_rd`=0 starts a write to address A. The value of `dq_in` at the K edge two enabled edges later is stored at A. The value at the following K# edge is stored at the burst partner of A.
- R4: With `LAT25`=0, on a K edge `ld_n`=0 with `rw_rd`=1 starts a read of A. The word at A is on `dq_out` with `dq_oe`=1 after the 4th enabled edge counted from the command edge. The partner word follows after the 5th.
- R5: With `LAT25`=1, the first read beat appears after the 5th enabled edge, which is a K# edge, and the second beat after the 6th, which is a K edge.
- R6: `ld_n`=1 on a K edge is a no-op whatever `rw_rd`, `addr` and `dq_in` are. Nothing is stored, and no new read beats are produced.
- R7: The burst partner of A is A with bit 0 inverted. All other bits are unchanged, so an odd start address wraps down to its even neighbour.
- R8: A read issued on the K edge right after a write to the same pair of words returns the newly written beats.
- R9: A write issued on the K edge right after a read does not change the beats that read returns, for either latency.
- R10: Reads issued on consecutive K edges keep `dq_oe` high without a gap. The beats come out in command order.
- R11: While `ck_en` is 0, no edge is counted. `dq_out`, `dq_oe` and `k_slot` hold, and the controls, the address and the data are ignored.
- R12: Whenever `dq_oe` is 0, `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; its enabled edges alternate K, K# |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_en | input | 1 | Clock enable; 0 models a stopped K clock |
| ld_n | input | 1 | Command load, active low, sampled on K edges |
| rw_rd | input | 1 | 1 selects read, 0 selects write |
| addr | input | AW | Burst start address |
| dq_in | input | DW | Write data beats from the bus |
| dq_out | output | DW | Read data beats onto the bus |
| dq_oe | output | 1 | Bus drive enable for `dq_out` |
| k_slot | output | 1 | High when the next enabled edge is a K edge |

## Verification
Every result is due a fixed number of enabled edges after the K edge that carried its command. Write beats are taken 2 and 3 edges after the command. Read beats are visible after 4 and 5 edges with the 2.0 latency, or after 5 and 6 with the 2.5 latency. The bench runs both latency variants side by side from the same stimulus. It numbers enabled edges itself, so a stall moves every due slot along with the pipeline. At each command it books the expected bus value into the slot where that value is due, and it compares that booking against both variants on the falling edge after each rising edge.

// File: rtl/b2s_pkg.sv
`timescale 1ns/1ps
package b2s_pkg;
  typedef enum logic {PH_K = 1'b0, PH_KN = 1'b1} phase_e;
  localparam int unsigned HALF_LAT_20 = 4;
  localparam int unsigned HALF_LAT_25 = 5;
endpackage

// File: rtl/b2s_phase.sv
`timescale 1ns/1ps
module b2s_phase import b2s_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  output phase_e ph
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (adv) ph_d = (ph_q == PH_K) ? PH_KN : PH_K;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_K;
    else        ph_q <= ph_d;
  end

  assign ph = ph_q;
endmodule

// File: rtl/b2s_cmd_pipe.sv
`timescale 1ns/1ps
module b2s_cmd_pipe #(
  parameter int AW   = 8,
  parameter int DW   = 18,
  parameter int HLAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic          load_rd,
  input  logic [AW-1:0] load_adr,
  input  logic [DW-1:0] att_d0,
  input  logic [DW-1:0] att_d1,
  output logic [AW-1:0] cap_adr,
  output logic          wr0_go,
  output logic [AW-1:0] wr0_adr,
  output logic          wr1_go,
  output logic [AW-1:0] wr1_adr,
  output logic          b0_go,
  output logic [DW-1:0] b0_dat,
  output logic          b1_go,
  output logic [DW-1:0] b1_dat
);
  localparam int NSTG = HLAT + 1;
  localparam logic [AW-1:0] PAIR_BIT = AW'(1);

  logic            st_vld [1:NSTG];
  logic            vld_nx [1:NSTG];
  logic            st_rd  [1:NSTG];
  logic            rd_nx  [1:NSTG];
  logic [AW-1:0]   st_adr [1:NSTG];
  logic [AW-1:0]   adr_nx [1:NSTG];
  logic [2*DW-1:0] st_dat [2:NSTG];
  logic [2*DW-1:0] dat_nx [2:NSTG];

  // next-state: stage 1 takes the command, stage 2 attaches read data
  always_comb begin
    vld_nx[1] = load;
    rd_nx[1]  = load_rd;
    adr_nx[1] = load_adr;
    for (int s = 2; s <= NSTG; s++) begin
      vld_nx[s] = st_vld[s-1];
      rd_nx[s]  = st_rd[s-1];
      adr_nx[s] = st_adr[s-1];
    end
    dat_nx[2] = {att_d1, att_d0};
    for (int s = 3; s <= NSTG; s++) begin
      dat_nx[s] = st_dat[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 1; s <= NSTG; s++) st_vld[s] <= 1'b0;
    end else if (adv) begin
      for (int s = 1; s <= NSTG; s++) st_vld[s] <= vld_nx[s];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int s = 1; s <= NSTG; s++) begin
        st_rd[s]  <= rd_nx[s];
        st_adr[s] <= adr_nx[s];
      end
      for (int s = 2; s <= NSTG; s++) st_dat[s] <= dat_nx[s];
    end
  end

  assign cap_adr = st_adr[1];
  assign wr0_go  = st_vld[2] & ~st_rd[2];
  assign wr0_adr = st_adr[2];
  assign wr1_go  = st_vld[3] & ~st_rd[3];
  assign wr1_adr = st_adr[3] ^ PAIR_BIT;
  assign b0_go   = st_vld[HLAT] & st_rd[HLAT];
  assign b0_dat  = st_dat[HLAT][DW-1:0];
  assign b1_go   = st_vld[NSTG] & st_rd[NSTG];
  assign b1_dat  = st_dat[NSTG][2*DW-1:DW];
endmodule

// File: rtl/b2s_store.sv
`timescale 1ns/1ps
module b2s_store #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_adr,
  input  logic [DW-1:0] wr_dat,
  input  logic [AW-1:0] rd0_adr,
  input  logic [AW-1:0] rd1_adr,
  output logic [DW-1:0] rd0_dat,
  output logic [DW-1:0] rd1_dat
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_adr] <= wr_dat;
  end

  // a beat being written on this edge is forwarded to a same-edge snapshot
  assign rd0_dat = (wr_en && (wr_adr == rd0_adr)) ? wr_dat : mem_q[rd0_adr];
  assign rd1_dat = (wr_en && (wr_adr == rd1_adr)) ? wr_dat : mem_q[rd1_adr];
endmodule

// File: rtl/b2s_drive.sv
`timescale 1ns/1ps
module b2s_drive #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          b0_go,
  input  logic [DW-1:0] b0_dat,
  input  logic          b1_go,
  input  logic [DW-1:0] b1_dat,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic [DW-1:0] out_q, out_d;
  logic          oe_q, oe_d;

  always_comb begin
    out_d = out_q;
    oe_d  = oe_q;
    if (adv) begin
      oe_d = b0_go | b1_go;
      if (b0_go)      out_d = b0_dat;
      else if (b1_go) out_d = b1_dat;
      else            out_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = oe_q;
endmodule

// File: rtl/burst2_ddr_sram.sv
`timescale 1ns/1ps
module burst2_ddr_sram import b2s_pkg::*; #(
  parameter int AW    = 8,
  parameter int DW    = 18,
  parameter bit LAT25 = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ck_en,
  input  logic          ld_n,
  input  logic          rw_rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          k_slot
);
  localparam int HLAT = LAT25 ? int'(HALF_LAT_25) : int'(HALF_LAT_20);
  localparam logic [AW-1:0] PAIR_BIT = AW'(1);

  logic [1:0]    rst_sync_q;
  logic          rst_q_n;
  phase_e        ph;
  logic          adv, k_now, cmd_load;
  logic [AW-1:0] cap_adr, wr0_adr, wr1_adr, wr_adr;
  logic          wr0_go, wr1_go, wr_en;
  logic [DW-1:0] snap0, snap1;
  logic          b0_go, b1_go;
  logic [DW-1:0] b0_dat, b1_dat;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign adv      = ck_en;
  assign k_now    = (ph == PH_K);
  assign k_slot   = k_now;
  assign cmd_load = adv & k_now & ~ld_n;

  b2s_phase u_phase (
    .clk   (clk),
    .rst_n (rst_q_n),
    .adv   (adv),
    .ph    (ph)
  );

  b2s_cmd_pipe #(.AW(AW), .DW(DW), .HLAT(HLAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .adv      (adv),
    .load     (cmd_load),
    .load_rd  (rw_rd),
    .load_adr (addr),
    .att_d0   (snap0),
    .att_d1   (snap1),
    .cap_adr  (cap_adr),
    .wr0_go   (wr0_go),
    .wr0_adr  (wr0_adr),
    .wr1_go   (wr1_go),
    .wr1_adr  (wr1_adr),
    .b0_go    (b0_go),
    .b0_dat   (b0_dat),
    .b1_go    (b1_go),
    .b1_dat   (b1_dat)
  );

  // the two beats of one write fall on different edges: one port suffices
  assign wr_en  = adv & (wr0_go | wr1_go);
  assign wr_adr = wr0_go ? wr0_adr : wr1_adr;

  b2s_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_adr  (wr_adr),
    .wr_dat  (dq_in),
    .rd0_adr (cap_adr),
    .rd1_adr (cap_adr ^ PAIR_BIT),
    .rd0_dat (snap0),
    .rd1_dat (snap1)
  );

  b2s_drive #(.DW(DW)) u_drive (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .adv    (adv),
    .b0_go  (b0_go),
    .b0_dat (b0_dat),
    .b1_go  (b1_go),
    .b1_dat (b1_dat),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
  );
endmodule

// File: rtl/b2s_chk.sv
`timescale 1ns/1ps
module b2s_chk #(
  parameter int DW    = 18,
  parameter bit LAT25 = 1'b0
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          ck_en,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          k_slot
);
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    ck_en |=> (k_slot != $past(k_slot))); // R2

  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(dq_oe) |=> dq_oe); // R4

  AST_FIRST_BEAT_EDGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(dq_oe) |-> (k_slot == LAT25)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ck_en |=> ($stable(dq_oe) && $stable(dq_out) && $stable(k_slot))); // R11

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dq_oe |-> (dq_out == '0)); // R12
endmodule

bind burst2_ddr_sram b2s_chk #(.DW(DW), .LAT25(LAT25)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .ck_en   (ck_en),
  .dq_oe   (dq_oe),
  .dq_out  (dq_out),
  .k_slot  (k_slot)
);

// File: tb/burst2_ddr_sram_tb.sv
`timescale 1ns/1ps
module burst2_ddr_sram_tb;
  localparam int AW   = 8;
  localparam int DW   = 18;
  localparam int RING = 1024;

  logic          clk = 1'b0;
  logic          rst_n, ck_en, ld_n, rw_rd;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] out_a, out_b;
  logic          oe_a, oe_b, k_a, k_b;

  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;
  int unsigned   slot = 0;
  string         cur_tag = "R1";

  logic [DW-1:0] mdl [0:(1<<AW)-1];
  logic [DW-1:0] sd [0:RING-1];
  bit            sv [0:RING-1];
  bit            ea_oe [0:RING-1];
  bit            eb_oe [0:RING-1];
  logic [DW-1:0] ea_dq [0:RING-1];
  logic [DW-1:0] eb_dq [0:RING-1];

  always #2 clk = ~clk;

  burst2_ddr_sram #(.AW(AW), .DW(DW), .LAT25(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ck_en(ck_en), .ld_n(ld_n), .rw_rd(rw_rd),
    .addr(addr), .dq_in(dq_in), .dq_out(out_a), .dq_oe(oe_a), .k_slot(k_a)
  );

  burst2_ddr_sram #(.AW(AW), .DW(DW), .LAT25(1'b1)) u_dut_l25 (
    .clk(clk), .rst_n(rst_n), .ck_en(ck_en), .ld_n(ld_n), .rw_rd(rw_rd),
    .addr(addr), .dq_in(dq_in), .dq_out(out_b), .dq_oe(oe_b), .k_slot(k_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (slot %0d)", tag, act, exp, slot);
    end
  endtask

  // one enabled-or-stalled edge, then compare both variants with the booked slot
  task automatic step();
    int unsigned nx;
    int unsigned cs;
    nx = (slot + 1) % RING;
    dq_in = sv[nx] ? sd[nx] : DW'($urandom);
    @(posedge clk);
    if (ck_en) begin
      sv[nx] = 1'b0;
      ea_oe[slot % RING] = 1'b0;
      eb_oe[slot % RING] = 1'b0;
      slot++;
    end
    @(negedge clk);
    cs = slot % RING;
    chk(cur_tag, 32'(oe_a), 32'(ea_oe[cs]));
    chk(cur_tag, 32'(oe_b), 32'(eb_oe[cs]));
    if (ea_oe[cs]) chk(cur_tag, 32'(out_a), 32'(ea_dq[cs]));
    else           chk("R12", 32'(out_a), 32'd0);
    if (eb_oe[cs]) chk(cur_tag, 32'(out_b), 32'(eb_dq[cs]));
    else           chk("R12", 32'(out_b), 32'd0);
    chk("R2", 32'(k_a), 32'(slot % 2 == 0));
    chk("R2", 32'(k_b), 32'(slot % 2 == 0));
  endtask

  // one full K cycle: K edge carries the command, K# edge carries optional noise
  task automatic kcyc(input bit ldn, input bit rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                      input bit kn_noise, input logic [AW-1:0] na);
    int unsigned c;
    c = slot + 1;
    ck_en = 1'b1; ld_n = ldn; rw_rd = rd; addr = a;
    if (!ldn && !rd) begin
      mdl[a] = w0; mdl[a ^ AW'(1)] = w1;
      sd[(c+2) % RING] = w0; sv[(c+2) % RING] = 1'b1;
      sd[(c+3) % RING] = w1; sv[(c+3) % RING] = 1'b1;
    end
    if (!ldn && rd) begin
      ea_oe[(c+4) % RING] = 1'b1; ea_dq[(c+4) % RING] = mdl[a];
      ea_oe[(c+5) % RING] = 1'b1; ea_dq[(c+5) % RING] = mdl[a ^ AW'(1)];
      eb_oe[(c+5) % RING] = 1'b1; eb_dq[(c+5) % RING] = mdl[a];
      eb_oe[(c+6) % RING] = 1'b1; eb_dq[(c+6) % RING] = mdl[a ^ AW'(1)];
    end
    step();
    ld_n  = kn_noise ? 1'b0 : 1'b1;
    rw_rd = kn_noise ? 1'($urandom) : 1'b0;
    addr  = na;
    step();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] w0, input logic [DW-1:0] w1);
    kcyc(1'b0, 1'b0, a, w0, w1, 1'b0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    kcyc(1'b0, 1'b1, a, '0, '0, 1'b0, '0);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) kcyc(1'b1, 1'b0, '0, '0, '0, 1'b0, '0);
  endtask

  task automatic stall(input int n, input logic [AW-1:0] na);
    ck_en = 1'b0; ld_n = 1'b0; rw_rd = 1'b0; addr = na;
    for (int i = 0; i < n; i++) step();
    ck_en = 1'b1; ld_n = 1'b1;
  endtask

  task automatic t_reset();
    cur_tag = "R1";
    chk("R1", 32'(oe_a), 32'd0);
    chk("R1", 32'(oe_b), 32'd0);
    chk("R1", 32'(out_a), 32'd0);
    chk("R1", 32'(out_b), 32'd0);
    chk("R1", 32'(k_a), 32'd1);
    chk("R1", 32'(k_b), 32'd1);
  endtask

  task automatic t_basic();
    cur_tag = "R3 R4 R5";
    wr(8'h10, 18'h1A5A5, 18'h0F0F0);
    nops(1);
    rd(8'h10);
    nops(4);
  endtask

  task automatic t_wrap();
    cur_tag = "R7";
    wr(8'h21, 18'h21111, 18'h20000);
    nops(1);
    rd(8'h20);
    nops(1);
    rd(8'h21);
    nops(4);
  endtask

  task automatic t_nop();
    cur_tag = "R6";
    wr(8'h50, 18'h05555, 18'h0AAAA);
    for (int i = 0; i < 3; i++) kcyc(1'b1, 1'b0, 8'h50, '0, '0, 1'b0, 8'h51);
    for (int i = 0; i < 2; i++) kcyc(1'b1, 1'b1, 8'h51, '0, '0, 1'b0, 8'h50);
    rd(8'h50);
    nops(4);
  endtask

  task automatic t_kn_ignore();
    cur_tag = "R2";
    wr(8'h40, 18'h3C3C3, 18'h1E1E1);
    nops(1);
    for (int i = 0; i < 4; i++) kcyc(1'b1, 1'b0, 8'h00, '0, '0, 1'b1, 8'h40);
    nops(2);
    rd(8'h40);
    nops(4);
  endtask

  task automatic t_raw();
    cur_tag = "R8";
    wr(8'h30, 18'h12345, 18'h2468A);
    rd(8'h30);
    rd(8'h31);
    nops(4);
  endtask

  task automatic t_war();
    cur_tag = "R9";
    rd(8'h30);
    wr(8'h30, 18'h0BEEF, 18'h0CAFE);
    rd(8'h30);
    nops(4);
  endtask

  task automatic t_stream();
    cur_tag = "R10";
    wr(8'h60, 18'h00601, 18'h00611);
    wr(8'h62, 18'h00622, 18'h00632);
    rd(8'h60);
    rd(8'h61);
    rd(8'h62);
    rd(8'h63);
    nops(5);
  endtask

  task automatic t_stall();
    cur_tag = "R11";
    rd(8'h60);
    nops(1);
    stall(3, 8'h60);
    nops(2);
    stall(2, 8'h62);
    nops(4);
    rd(8'h60);
    rd(8'h62);
    nops(5);
  endtask

  initial begin
    for (int i = 0; i < RING; i++) begin
      sv[i] = 1'b0; ea_oe[i] = 1'b0; eb_oe[i] = 1'b0;
      sd[i] = '0; ea_dq[i] = '0; eb_dq[i] = '0;
    end
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    rst_n = 1'b0; ck_en = 1'b0; ld_n = 1'b1; rw_rd = 1'b0; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // clear storage used later so unwritten words are known
    for (int a = 0; a < 128; a += 2) wr(8'(a), '0, '0);
    nops(2);
    t_basic();
    t_wrap();
    t_nop();
    t_kn_ignore();
    t_raw();
    t_war();
    t_stream();
    t_stall();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule